// File: doc/BRIEF.md
# AES Round Unit

A single-cycle datapath that performs one round of the AES cipher on a 128-bit state with a 128-bit round key. A 3-bit operation code picks one of five modes: a middle encryption round, the closing encryption round, a middle decryption round, the closing decryption round, or a key-conditioning mode. The key-conditioning mode applies InvMixColumns to the round key alone. It turns the middle expanded round keys into the keys that the equivalent inverse cipher needs for decryption.

One result is produced per accepted request. A caller chains ten calls to encrypt or decrypt a block. Key expansion and round sequencing stay with the caller. An extra 128-bit upper half rides along with each request and comes back untouched, so the unit can sit behind a 256-bit destination register whose upper half must keep its value.

Top module: `aes_round_unit`

## Requirements
- R1: Op code 0 (middle encryption round) yields MixColumns(SubBytes(ShiftRows(state))) XOR key.
- R2: Op code 1 (closing encryption round) yields SubBytes(ShiftRows(state)) XOR key, with no column mix.
- R3: Op code 2 (middle decryption round) yields InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key.
- R4: Op code 3 (closing decryption round) yields InvSubBytes(InvShiftRows(state)) XOR key, with no column mix.
- R5: Op code 4 (key conditioning) yields InvMixColumns(key). The state input has no effect, and no S-box, row shift or key XOR is applied.
- R6: `resOut` and `vldOut` change at the first rising clock edge after `vldIn` is sampled high. `vldOut` is high exactly in the cycles that follow a cycle with `vldIn` high.
- R7: While `vldIn` is low, `resOut` and `hiOut` hold their values, whatever the other inputs do.
- R8: `hiOut` takes the value of `hiIn` with the same one-cycle timing as the result, unmodified in every mode.
- R9: Op codes 5, 6 and 7 return the state input unchanged.
- R10: During and right after reset, `vldOut`, `resOut` and `hiOut` are all zero.
- R11: Byte i of the state occupies bits 8i+7:8i and stands at row i mod 4, column i div 4. With this layout, chaining the modes over the standard 128-bit test key gives the standard ciphertext, and decryption through the conditioned keys returns the plaintext.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| vldIn | input | 1 | Request strobe |
| opSel | input | 3 | Operation code (0 to 4 defined, 5 to 7 pass the state through) |
| stateIn | input | 128 | State, column-major bytes |
| keyIn | input | 128 | Round key, or the operand of op code 4 |
| hiIn | input | 128 | Upper half of the destination view |
| vldOut | output | 1 | Result strobe |
| resOut | output | 128 | Round result |
| hiOut | output | 128 | Upper half, returned unchanged |

## Verification
Each result, together with its strobe and its upper half, is due exactly one clock after the request cycle. The bench drives inputs on the falling edge. It carries a model whose expected outputs are updated on every step, and it compares all three outputs at the following falling edge. Idle steps change the data inputs freely, so the same comparison also covers the hold rule. The round-trip test feeds each sampled result into the next request, so a single slip in timing or byte layout corrupts the final block.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

  typedef enum logic [2:0] {
    OP_ENC      = 3'd0,
    OP_ENC_LAST = 3'd1,
    OP_DEC      = 3'd2,
    OP_DEC_LAST = 3'd3,
    OP_KEYMIX   = 3'd4
  } opCode_e;

  typedef struct packed {
    logic load;
    logic inv;
    logic keySrc;
    logic shift;
    logic sub;
    logic mix;
    logic addKey;
  } rndCtrl_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gfMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc, cur;
    acc = 8'h00;
    cur = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ cur;
      cur = xt(cur);
    end
    return acc;
  endfunction

  // x^254 is the multiplicative inverse (0 maps to 0)
  function automatic logic [7:0] gfInv(input logic [7:0] x);
    logic [7:0] p, r;
    p = x;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      p = gfMul(p, p);
      r = gfMul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] x, input int n);
    return (x << n) | (x >> (8 - n));
  endfunction

  // shared inverter: inverse affine before it for decryption, forward affine after it for encryption
  function automatic logic [7:0] subByte(input logic [7:0] x, input logic inv);
    logic [7:0] pre, z;
    pre = inv ? (rotl(x, 1) ^ rotl(x, 3) ^ rotl(x, 6) ^ 8'h05) : x;
    z   = gfInv(pre);
    return inv ? z : (z ^ rotl(z, 1) ^ rotl(z, 2) ^ rotl(z, 3) ^ rotl(z, 4) ^ 8'h63);
  endfunction

  function automatic logic [31:0] mixCol(input logic [31:0] col, input logic inv);
    logic [7:0] a [4];
    logic [7:0] x2, x4, x8;
    logic [7:0] m1 [4], m2 [4], m3 [4], m9 [4], m11 [4], m13 [4], m14 [4];
    logic [31:0] o;
    for (int r = 0; r < 4; r++) begin
      a[r]   = col[8*r +: 8];
      x2     = xt(a[r]);
      x4     = xt(x2);
      x8     = xt(x4);
      m1[r]  = a[r];
      m2[r]  = x2;
      m3[r]  = x2 ^ a[r];
      m9[r]  = x8 ^ a[r];
      m11[r] = x8 ^ x2 ^ a[r];
      m13[r] = x8 ^ x4 ^ a[r];
      m14[r] = x8 ^ x4 ^ x2;
    end
    for (int r = 0; r < 4; r++) begin
      if (inv)
        o[8*r +: 8] = m14[r] ^ m11[(r+1)%4] ^ m13[(r+2)%4] ^ m9[(r+3)%4];
      else
        o[8*r +: 8] = m2[r] ^ m3[(r+1)%4] ^ m1[(r+2)%4] ^ m1[(r+3)%4];
    end
    return o;
  endfunction

endpackage

// File: rtl/aes_rnd_ctrl.sv
module aes_rnd_ctrl
  import aes_rnd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       vldIn,
  input  logic [2:0] opSel,
  output rndCtrl_t   ctrl,
  output logic       vldOut
);

  always_comb begin
    ctrl      = '0;
    ctrl.load = vldIn;
    case (opSel)
      OP_ENC:      begin ctrl.shift = 1'b1; ctrl.sub = 1'b1; ctrl.mix = 1'b1; ctrl.addKey = 1'b1; end
      OP_ENC_LAST: begin ctrl.shift = 1'b1; ctrl.sub = 1'b1; ctrl.addKey = 1'b1; end
      OP_DEC:      begin ctrl.inv = 1'b1; ctrl.shift = 1'b1; ctrl.sub = 1'b1; ctrl.mix = 1'b1; ctrl.addKey = 1'b1; end
      OP_DEC_LAST: begin ctrl.inv = 1'b1; ctrl.shift = 1'b1; ctrl.sub = 1'b1; ctrl.addKey = 1'b1; end
      OP_KEYMIX:   begin ctrl.inv = 1'b1; ctrl.keySrc = 1'b1; ctrl.mix = 1'b1; end
      default:     ; // reserved: state passes through
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) vldOut <= 1'b0;
    else     vldOut <= vldIn;
  end

endmodule

// File: rtl/aes_rnd_dp.sv
module aes_rnd_dp
  import aes_rnd_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int HI_W  = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  rndCtrl_t         ctrl,
  input  logic [BLK_W-1:0] stateIn,
  input  logic [BLK_W-1:0] keyIn,
  input  logic [HI_W-1:0]  hiIn,
  output logic [BLK_W-1:0] resOut,
  output logic [HI_W-1:0]  hiOut
);

  localparam int NB = BLK_W / 8;
  localparam int NC = NB / 4;

  logic [BLK_W-1:0] opnd, shifted, subbed, mixed, nextRes;

  assign opnd = ctrl.keySrc ? keyIn : stateIn;

  for (genvar c = 0; c < NC; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int DST  = 4*c + r;
      localparam int SRCF = r + 4*((c + r) % NC);
      localparam int SRCI = r + 4*((c - r + NC) % NC);
      logic [7:0] rowByte;
      assign rowByte = ctrl.inv ? opnd[8*SRCI +: 8] : opnd[8*SRCF +: 8];
      assign shifted[8*DST +: 8] = ctrl.shift ? rowByte : opnd[8*DST +: 8];
      assign subbed[8*DST +: 8]  = ctrl.sub ? subByte(shifted[8*DST +: 8], ctrl.inv)
                                            : shifted[8*DST +: 8];
    end
    assign mixed[32*c +: 32] = ctrl.mix ? mixCol(subbed[32*c +: 32], ctrl.inv)
                                        : subbed[32*c +: 32];
  end

  assign nextRes = ctrl.addKey ? (mixed ^ keyIn) : mixed;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      resOut <= '0;
      hiOut  <= '0;
    end else if (ctrl.load) begin
      resOut <= nextRes;
      hiOut  <= hiIn;
    end
  end

  // R7: no load, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !ctrl.load |=> ($stable(resOut) && $stable(hiOut)));

endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_rnd_pkg::*;
#(
  parameter int BLK_W = 128,
  parameter int HI_W  = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vldIn,
  input  logic [2:0]       opSel,
  input  logic [BLK_W-1:0] stateIn,
  input  logic [BLK_W-1:0] keyIn,
  input  logic [HI_W-1:0]  hiIn,
  output logic             vldOut,
  output logic [BLK_W-1:0] resOut,
  output logic [HI_W-1:0]  hiOut
);

  rndCtrl_t ctrl;

  aes_rnd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .vldIn(vldIn), .opSel(opSel),
    .ctrl(ctrl), .vldOut(vldOut)
  );

  aes_rnd_dp #(.BLK_W(BLK_W), .HI_W(HI_W)) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .stateIn(stateIn), .keyIn(keyIn),
    .hiIn(hiIn), .resOut(resOut), .hiOut(hiOut)
  );

  p_vld_lat_r6: assert property (@(posedge clk) disable iff (rst)
    vldIn |=> vldOut);
  p_vld_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !vldIn |=> !vldOut);
  p_hi_pass_r8: assert property (@(posedge clk) disable iff (rst)
    vldIn |=> (hiOut == $past(hiIn)));
  p_rsv_pass_r9: assert property (@(posedge clk) disable iff (rst)
    (vldIn && opSel > 3'd4) |=> (resOut == $past(stateIn)));
  p_keymix_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (vldIn && opSel == 3'd4 && keyIn == '0) |=> (resOut == '0));

endmodule

// File: tb/aes_round_unit_bench.sv
`timescale 1ns/1ps
module aes_round_unit_bench;

  logic         clk = 1'b0;
  logic         rst;
  logic         vldIn;
  logic [2:0]   opSel;
  logic [127:0] stateIn, keyIn, hiIn;
  logic         vldOut;
  logic [127:0] resOut, hiOut;

  always #4 clk = ~clk;

  aes_round_unit u_aes_round_unit (
    .clk(clk), .rst(rst), .vldIn(vldIn), .opSel(opSel), .stateIn(stateIn),
    .keyIn(keyIn), .hiIn(hiIn), .vldOut(vldOut), .resOut(resOut), .hiOut(hiOut)
  );

  int total = 0;
  int bad   = 0;

  // behavioural tables built from logarithms
  logic [7:0] alg [256];
  int         lg  [256];
  logic [7:0] sb  [256];
  logic [7:0] isb [256];

  function automatic logic [7:0] mulB(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return alg[(lg[a] + lg[b]) % 255];
  endfunction

  task automatic buildTables();
    logic [7:0] x, inv, s;
    x = 8'h01;
    for (int i = 0; i < 255; i++) begin
      alg[i] = x;
      lg[x]  = i;
      x = x ^ ({x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00));
    end
    for (int i = 0; i < 256; i++) begin
      inv = (i == 0) ? 8'h00 : alg[(255 - lg[i]) % 255];
      s = 8'h63;
      for (int k = 0; k < 5; k++) s = s ^ ((inv << k) | (inv >> (8 - k)));
      sb[i] = s;
      isb[s] = i[7:0];
    end
  endtask

  function automatic logic [127:0] refRound(input logic [2:0] op, input logic [127:0] st,
                                           input logic [127:0] k);
    logic [7:0] a [16];
    logic [7:0] t [16];
    logic [7:0] m [16];
    logic [127:0] o;
    logic [7:0] cf [4];
    if (op > 3'd4) return st;
    for (int i = 0; i < 16; i++) a[i] = (op == 3'd4) ? k[8*i +: 8] : st[8*i +: 8];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        if (op == 3'd4)      t[4*c+r] = a[4*c+r];
        else if (op < 3'd2)  t[4*c+r] = sb[a[r + 4*((c+r)%4)]];
        else                 t[4*c+r] = isb[a[r + 4*((c-r+4)%4)]];
      end
    if (op == 3'd0) begin cf[0]=8'd2; cf[1]=8'd3; cf[2]=8'd1; cf[3]=8'd1; end
    else            begin cf[0]=8'd14; cf[1]=8'd11; cf[2]=8'd13; cf[3]=8'd9; end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        if (op == 3'd0 || op == 3'd2 || op == 3'd4)
          m[4*c+r] = mulB(cf[0], t[4*c+r]) ^ mulB(cf[1], t[4*c+(r+1)%4]) ^
                     mulB(cf[2], t[4*c+(r+2)%4]) ^ mulB(cf[3], t[4*c+(r+3)%4]);
        else
          m[4*c+r] = t[4*c+r];
      end
    for (int i = 0; i < 16; i++) o[8*i +: 8] = m[i];
    if (op != 3'd4) o = o ^ k;
    return o;
  endfunction

  function automatic logic [127:0] wr(input logic [127:0] v);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = v[127-8*i -: 8];
    return o;
  endfunction

  // model state
  logic         expV   = 1'b0;
  logic [127:0] expRes = '0;
  logic [127:0] expHi  = '0;
  bit           armed  = 0;
  string        pendTag = "";

  task automatic chk(input string tag, input string what, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input logic [127:0] st,
                      input logic [127:0] k, input logic [127:0] hi, input string tag);
    @(negedge clk);
    if (armed) begin
      chk(pendTag, "vldOut R6", {127'd0, vldOut}, {127'd0, expV});
      chk(pendTag, "resOut", resOut, expRes);
      chk(pendTag, "hiOut R8", hiOut, expHi);
    end
    armed   = 1;
    vldIn   = v;
    opSel   = op;
    stateIn = st;
    keyIn   = k;
    hiIn    = hi;
    expV    = v;
    if (v) begin
      expRes = refRound(op, st, k);
      expHi  = hi;
    end
    pendTag = tag;
  endtask

  logic [7:0]   ek [176];
  logic [127:0] rk [11];

  task automatic expandKey(input logic [127:0] key);
    logic [7:0] t [4];
    logic [7:0] rc, tmp;
    rc = 8'h01;
    for (int i = 0; i < 16; i++) ek[i] = key[8*i +: 8];
    for (int j = 4; j < 44; j++) begin
      for (int b = 0; b < 4; b++) t[b] = ek[4*(j-1)+b];
      if (j % 4 == 0) begin
        tmp = t[0];
        t[0] = sb[t[1]] ^ rc; t[1] = sb[t[2]]; t[2] = sb[t[3]]; t[3] = sb[tmp];
        rc = {rc[6:0], 1'b0} ^ (rc[7] ? 8'h1b : 8'h00);
      end
      for (int b = 0; b < 4; b++) ek[4*j+b] = ek[4*(j-4)+b] ^ t[b];
    end
    for (int n = 0; n < 11; n++)
      for (int i = 0; i < 16; i++) rk[n][8*i +: 8] = ek[16*n+i];
  endtask

  task automatic callDut(input logic [2:0] op, input logic [127:0] st, input logic [127:0] k,
                         input string tag, output logic [127:0] res);
    step(1, op, st, k, {st[63:0], k[63:0]}, tag);
    step(0, 3'd0, '0, '0, '0, tag);
    res = resOut;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [127:0] key, pt, ct, st, dk;
    buildTables();
    rst = 1'b1; vldIn = 0; opSel = 0; stateIn = '0; keyIn = '0; hiIn = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "vldOut", {127'd0, vldOut}, 128'd0);
    chk("R10", "resOut", resOut, '0);
    chk("R10", "hiOut", hiOut, '0);

    // R1..R4: each round mode under several patterns
    for (int n = 0; n < 6; n++) begin
      step(1, 3'd0, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R1");
      step(1, 3'd1, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R2");
      step(1, 3'd2, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R3");
      step(1, 3'd3, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R4");
    end
    step(1, 3'd0, '0, '0, '1, "R1");
    step(1, 3'd3, '1, '1, '0, "R4");
    // R5: state must not matter
    key = {$urandom, $urandom, $urandom, $urandom};
    for (int n = 0; n < 4; n++) step(1, 3'd4, {4{$urandom}}, key, {4{$urandom}}, "R5");
    step(1, 3'd4, '1, '0, '0, "R5");
    // R9: reserved codes
    for (int n = 5; n < 8; n++) step(1, n[2:0], {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R9");
    // R7: idle with churning inputs, then back-to-back requests (R6)
    for (int n = 0; n < 5; n++) step(0, n[2:0], {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R7");
    step(1, 3'd1, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R6");
    step(0, 3'd0, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R7");
    step(1, 3'd2, {4{$urandom}}, {4{$urandom}}, {4{$urandom}}, "R6");

    // R11: full chain with the standard test vector
    key = wr(128'h000102030405060708090a0b0c0d0e0f);
    pt  = wr(128'h00112233445566778899aabbccddeeff);
    ct  = wr(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    expandKey(key);
    st = pt ^ rk[0];
    for (int n = 1; n < 10; n++) callDut(3'd0, st, rk[n], "R11", st);
    callDut(3'd1, st, rk[10], "R11", st);
    chk("R11", "ciphertext", st, ct);
    st = ct ^ rk[10];
    for (int n = 9; n >= 1; n--) begin
      callDut(3'd4, {4{$urandom}}, rk[n], "R5", dk);
      callDut(3'd2, st, dk, "R11", st);
    end
    callDut(3'd3, st, rk[0], "R11", st);
    chk("R11", "plaintext", st, pt);

    step(0, 3'd0, '0, '0, '0, "R7");
    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule